// File: doc/BRIEF.md
# Handshaked PHY Control-Register Port Master

This block turns one register request into the series of strobe/acknowledge exchanges that a PHY's narrow control-register port expects. A requester presents an operation (write or read), a 16-bit address and 16-bit write data, then pulses `start`. The master drives a 20-bit control word toward the PHY and watches a 17-bit status word coming back. When the request ends, it pulses `done` and reports either read data or an error.

A write runs three exchanges: address capture, data capture, then the write strobe. A read runs two: address capture, then the read strobe, and the returned data is captured at that point. Every exchange works the same way. The data-in field is settled for a cycle with all strobes low. One strobe is then raised and held until ack goes high. The strobe is then dropped with data-in unchanged, and the master waits for ack to go low again. Each of the two ack waits is bounded. The limit is a number of polls, spaced by a prescaler that defaults to 1 µs at 250 MHz, with 100 polls by default.

Top module: `crport_master`

## Requirements
- R1: While reset is applied and after it is released, busy, done and error are 0 and the whole control word `phyCtl` is 0.
- R2: Control word layout: bit 0 is capture-address, bit 1 is capture-data, bits [17:2] carry data-in, bit 18 is read and bit 19 is write. For a write with address A and data D, the successive distinct values of `phyCtl` are A<<2, (A<<2)|1, A<<2, D<<2, (D<<2)|2, D<<2, (D<<2)|(1<<19), D<<2, and finally 0.
- R3: For a read with address A, the successive distinct values of `phyCtl` are A<<2, (A<<2)|1, A<<2, (A<<2)|(1<<18), A<<2, and finally 0. The read strobe carries the address on data-in.
- R4: Every strobe is raised only after at least one cycle in which all strobes were low and data-in already held the value that the strobe carries. A strobe is dropped only after ack (status bit 0) has been seen high, and data-in does not change when it is dropped. An exchange ends only once ack has been seen low.
- R5: With a PHY whose ack follows the strobe after Dly cycles, `done` is high for exactly one cycle, k·(2·Dly+3) cycles after the start edge, where k = 3 for a write and k = 2 for a read. `busy` is high from the cycle after the start edge through the done cycle, and is 0 in the cycle after that.
- R6: A read returns in `rdata` the status bits [16:1] sampled in the first cycle ack is high during the read strobe. `rdata` keeps this value through later writes and failed transactions.
- R7: If ack does not go high within TICK_CYCLES·POLL_LIMIT cycles of a strobe rising, the master ends the request. `phyCtl` goes to 0, `error` goes to 1 and `errPhase` to 0, `done` pulses, and no further exchange is started. An ack that arrives on the last allowed sample still counts as success.
- R8: If ack stays high for TICK_CYCLES·POLL_LIMIT cycles after a strobe drops, the request ends the same way but with `errPhase` = 1.
- R9: `start` is ignored while `busy` is high. A second request offered during a transaction produces no exchanges and no extra `done`.
- R10: At most one of the four strobe bits is high in any cycle.
- R11: `error` and `errPhase` keep their value until the next accepted `start` clears them. A transaction that completes reports `error` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| opRead | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Last transaction timed out |
| errPhase | output | 1 | Failed wait: 0 = ack rise, 1 = ack fall |
| rdata | output | 16 | Data captured by the last successful read |
| phyCtl | output | 20 | Control word to the PHY (strobes and data-in) |
| phyStat | input | 17 | Status word from the PHY: bit 0 ack, bits [16:1] data-out |

## Verification
A PHY model in the bench echoes the strobe as ack after a programmable delay Dly. With that model, a strobe appears one cycle after its setup cycle. The drop follows Dly+1 cycles later, and the next setup cycle comes Dly+1 cycles after that. This puts `done` k·(2·Dly+3) cycles after the start edge. A timeout while waiting for ack to rise ends the request 1+N cycles after its strobe's setup edge, and a timeout while waiting for ack to fall ends it Dly+2+N cycles after that edge, with N = TICK_CYCLES·POLL_LIMIT. The bench counts falling edges from the start edge until it sees `done`, and compares the count with these figures. It samples every output on the falling edge, half a cycle after the register that drives it changes. It checks the order of exchanges by logging each change of `phyCtl` at falling edges, so the order is checked independently of exact timing.

// File: rtl/crport_pkg.sv
package crport_pkg;

  // Step kind; the numeric value is also the strobe bit index in the
  // internal strobe vector {write, read, capData, capAddr}.
  typedef enum logic [1:0] {
    STEP_ADDR = 2'd0,
    STEP_DATA = 2'd1,
    STEP_RD   = 2'd2,
    STEP_WR   = 2'd3
  } step_e;

  typedef struct packed {
    logic  loadReq;   // latch request, put address on data-in
    logic  loadStep;  // put the value of step on data-in, strobes low
    logic  raiseStb;  // raise the strobe of step
    logic  dropStb;   // drop all strobes, keep data-in
    logic  latchRd;   // capture returned data
    logic  clrCtl;    // clear the whole control word
    logic  runTimer;  // advance the poll timer
    logic  clrTimer;  // restart the poll timer
    logic  setErr;    // record a timeout
    logic  errPhase;  // 0 = rise wait, 1 = fall wait
    step_e step;
  } ctlCmd_t;

endpackage

// File: rtl/crport_ctrl.sv
module crport_ctrl
  import crport_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     reqRead,
  input  logic     ack,
  input  logic     timeoutHit,
  output ctlCmd_t  cmd,
  output logic     busy,
  output logic     done
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RISE, S_FALL, S_FINISH} state_e;

  state_e state, stateNxt;
  step_e  step, stepNxt, nextStep;
  logic   lastStep;

  assign nextStep = (step == STEP_ADDR) ? (reqRead ? STEP_RD : STEP_DATA) : STEP_WR;
  assign lastStep = (step == STEP_RD) || (step == STEP_WR);

  always_comb begin
    cmd      = '0;
    cmd.step = step;
    stateNxt = state;
    stepNxt  = step;
    case (state)
      S_IDLE: begin
        if (start) begin
          cmd.loadReq = 1'b1;
          stepNxt     = STEP_ADDR;
          stateNxt    = S_SETUP;
        end
      end
      S_SETUP: begin
        cmd.raiseStb = 1'b1;
        cmd.clrTimer = 1'b1;
        stateNxt     = S_RISE;
      end
      S_RISE: begin
        if (ack) begin
          cmd.dropStb  = 1'b1;
          cmd.clrTimer = 1'b1;
          cmd.latchRd  = (step == STEP_RD);
          stateNxt     = S_FALL;
        end else if (timeoutHit) begin
          cmd.setErr   = 1'b1;
          cmd.errPhase = 1'b0;
          cmd.clrCtl   = 1'b1;
          stateNxt     = S_FINISH;
        end else begin
          cmd.runTimer = 1'b1;
        end
      end
      S_FALL: begin
        if (!ack) begin
          if (lastStep) begin
            cmd.clrCtl = 1'b1;
            stateNxt   = S_FINISH;
          end else begin
            cmd.loadStep = 1'b1;
            cmd.step     = nextStep;
            stepNxt      = nextStep;
            stateNxt     = S_SETUP;
          end
        end else if (timeoutHit) begin
          cmd.setErr   = 1'b1;
          cmd.errPhase = 1'b1;
          cmd.clrCtl   = 1'b1;
          stateNxt     = S_FINISH;
        end else begin
          cmd.runTimer = 1'b1;
        end
      end
      S_FINISH: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= STEP_ADDR;
    end else begin
      state <= stateNxt;
      step  <= stepNxt;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

endmodule

// File: rtl/crport_dp.sv
module crport_dp
  import crport_pkg::*;
#(
  parameter int DIN_W       = 16,
  parameter int DOUT_W      = 16,
  parameter int TICK_CYCLES = 250,
  parameter int POLL_LIMIT  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlCmd_t           cmd,
  input  logic              opRead,
  input  logic [DIN_W-1:0]  addr,
  input  logic [DIN_W-1:0]  wdata,
  input  logic [DOUT_W:0]   phyStat,
  output logic              reqRead,
  output logic              ack,
  output logic              timeoutHit,
  output logic [DIN_W+3:0]  phyCtl,
  output logic [DOUT_W-1:0] rdata,
  output logic              error,
  output logic              errPhase
);

  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYCLES - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

  logic [DIN_W-1:0]  reqAddr, reqData, dataIn;
  logic [3:0]        stb;   // {write, read, capData, capAddr}
  logic [TICK_W-1:0] tickCnt;
  logic [POLL_W-1:0] pollCnt;

  assign ack        = phyStat[0];
  assign phyCtl     = {stb[3], stb[2], dataIn, stb[1], stb[0]};
  assign timeoutHit = (tickCnt == TICK_LAST) && (pollCnt == POLL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqRead  <= 1'b0;
      reqAddr  <= '0;
      reqData  <= '0;
      dataIn   <= '0;
      stb      <= '0;
      rdata    <= '0;
      error    <= 1'b0;
      errPhase <= 1'b0;
    end else begin
      if (cmd.loadReq) begin
        reqRead  <= opRead;
        reqAddr  <= addr;
        reqData  <= wdata;
        dataIn   <= addr;
        stb      <= '0;
        error    <= 1'b0;
        errPhase <= 1'b0;
      end
      if (cmd.loadStep) begin
        dataIn <= (cmd.step == STEP_ADDR || cmd.step == STEP_RD) ? reqAddr : reqData;
        stb    <= '0;
      end
      if (cmd.raiseStb) stb <= 4'(1) << cmd.step;
      if (cmd.dropStb)  stb <= '0;
      if (cmd.clrCtl) begin
        stb    <= '0;
        dataIn <= '0;
      end
      if (cmd.setErr) begin
        error    <= 1'b1;
        errPhase <= cmd.errPhase;
      end
      if (cmd.latchRd) rdata <= phyStat[DOUT_W:1];
    end
  end

  // Poll timer: prescaler of TICK_CYCLES cycles, POLL_LIMIT polls.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      pollCnt <= '0;
    end else if (cmd.clrTimer) begin
      tickCnt <= '0;
      pollCnt <= '0;
    end else if (cmd.runTimer) begin
      if (tickCnt == TICK_LAST) begin
        tickCnt <= '0;
        pollCnt <= pollCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crport_master.sv
module crport_master
  import crport_pkg::*;
#(
  parameter int DIN_W       = 16,
  parameter int DOUT_W      = 16,
  parameter int TICK_CYCLES = 250,
  parameter int POLL_LIMIT  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opRead,
  input  logic [DIN_W-1:0]  addr,
  input  logic [DIN_W-1:0]  wdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              errPhase,
  output logic [DOUT_W-1:0] rdata,
  output logic [DIN_W+3:0]  phyCtl,
  input  logic [DOUT_W:0]   phyStat
);

  ctlCmd_t cmd;
  logic    reqRead, ack, timeoutHit;

  crport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqRead(reqRead),
    .ack(ack), .timeoutHit(timeoutHit), .cmd(cmd), .busy(busy), .done(done)
  );

  crport_dp #(
    .DIN_W(DIN_W), .DOUT_W(DOUT_W),
    .TICK_CYCLES(TICK_CYCLES), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .opRead(opRead), .addr(addr),
    .wdata(wdata), .phyStat(phyStat), .reqRead(reqRead), .ack(ack),
    .timeoutHit(timeoutHit), .phyCtl(phyCtl), .rdata(rdata),
    .error(error), .errPhase(errPhase)
  );

endmodule

// File: rtl/crport_master_chk.sv
module crport_master_chk #(
  parameter int DIN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic             ack,
  input logic [DIN_W+3:0] phyCtl
);

  logic [3:0]       stbBits;
  logic             anyStb;
  logic [DIN_W-1:0] dIn;

  assign stbBits = {phyCtl[DIN_W+3], phyCtl[DIN_W+2], phyCtl[1], phyCtl[0]};
  assign anyStb  = |stbBits;
  assign dIn     = phyCtl[DIN_W+1:2];

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stbBits) <= 1);

  p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyStb) |-> ($past(dIn) == dIn) && $past(busy));

  p_drop_after_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStb) && !error |-> $past(ack) && $stable(dIn));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_timeout_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done && !anyStb && (dIn == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !anyStb);

endmodule

bind crport_master crport_master_chk #(.DIN_W(DIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .error(error),
  .ack(phyStat[0]), .phyCtl(phyCtl)
);

// File: tb/crport_master_bench.sv
module crport_master_bench;

  localparam int TICK = 3;
  localparam int LIM  = 5;
  localparam int NWAIT = TICK * LIM;
  localparam logic [19:0] RD_BIT = 20'h40000;
  localparam logic [19:0] WR_BIT = 20'h80000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opRead = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, error, errPhase;
  logic [15:0] rdata;
  logic [19:0] phyCtl;
  logic [16:0] phyStat;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  crport_master #(.TICK_CYCLES(TICK), .POLL_LIMIT(LIM)) u_crport_master (
    .clk(clk), .rstN(rstN), .start(start), .opRead(opRead), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .error(error),
    .errPhase(errPhase), .rdata(rdata), .phyCtl(phyCtl), .phyStat(phyStat)
  );

  // ---------------- PHY model ----------------
  int          ackDly = 1;
  int          mode = 0;        // 0 echo, 1 never ack, 2 ack sticks high
  logic        modelClr = 1'b1;
  logic [15:0] pipe;
  logic        sticky;
  logic [15:0] capReg;
  logic        pipeOut, ackM;

  always @(posedge clk) begin
    if (modelClr) begin
      pipe   <= '0;
      sticky <= 1'b0;
    end else begin
      pipe <= {pipe[14:0], (phyCtl[0] | phyCtl[1] | phyCtl[18] | phyCtl[19])};
      if (pipeOut) sticky <= 1'b1;
    end
    if (phyCtl[0]) capReg <= phyCtl[17:2];
  end

  always_comb begin
    pipeOut = pipe[ackDly-1];
    ackM    = (mode == 1) ? 1'b0 : (mode == 2) ? (pipeOut | sticky) : pipeOut;
    phyStat = {(ackM ? (capReg ^ 16'hA5C3) : 16'hDEAD), ackM};
  end

  // ---------------- control word log ----------------
  logic [19:0] gotLog [16];
  int          gotN = 0;
  logic [19:0] lastCtl = '0;
  logic        logClr = 1'b0;

  always @(negedge clk) begin
    if (logClr) begin
      gotN    = 0;
      lastCtl = phyCtl;
    end else if (phyCtl !== lastCtl) begin
      if (gotN < 16) gotLog[gotN] = phyCtl;
      gotN++;
      lastCtl = phyCtl;
    end
  end

  logic [19:0] expLog [16];
  int          expN;

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [19:0] v);
    expLog[expN] = v;
    expN++;
  endtask

  task automatic expWrite(input logic [15:0] a, input logic [15:0] d);
    logic [19:0] av, dv;
    av = {2'b00, a, 2'b00};
    dv = {2'b00, d, 2'b00};
    expN = 0;
    push(av); push(av | 20'd1); push(av);
    push(dv); push(dv | 20'd2); push(dv); push(dv | WR_BIT); push(dv); push(20'd0);
  endtask

  task automatic expRead(input logic [15:0] a);
    logic [19:0] av;
    av = {2'b00, a, 2'b00};
    expN = 0;
    push(av); push(av | 20'd1); push(av); push(av | RD_BIT); push(av); push(20'd0);
  endtask

  task automatic checkLog(input string tag);
    bit ok;
    int at;
    ok = (gotN == expN);
    at = -1;
    for (int i = 0; i < 16; i++) begin
      if (ok && i < expN && gotLog[i] !== expLog[i]) begin
        ok = 1'b0;
        at = i;
      end
    end
    if (at >= 0) chk(tag, 1'b0, {12'd0, gotLog[at]}, {12'd0, expLog[at]});
    else         chk(tag, ok, gotN, expN);
  endtask

  task automatic quiet(input int n);
    modelClr = 1'b1;
    repeat (n) @(negedge clk);
    modelClr = 1'b0;
  endtask

  task automatic launch(input bit rd, input logic [15:0] a, input logic [15:0] d);
    logClr = 1'b1;
    @(negedge clk);
    #1 logClr = 1'b0;
    start = 1'b1; opRead = rd; addr = a; wdata = d;
    @(posedge clk);
    #1 start = 1'b0;
    chk("R5 busy after start", busy === 1'b1, busy, 1);
  endtask

  // counts cycles from the start edge until done is seen
  task automatic waitDone(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      n++;
      if (n > 2000) begin
        chk("R5 done never seen", 1'b0, n, 0);
        break;
      end
    end
  endtask

  task automatic afterDone();
    @(negedge clk);
    chk("R5 done one cycle", done === 1'b0, done, 0);
    chk("R5 busy released", busy === 1'b0, busy, 0);
  endtask

  initial begin
    int n;
    logic [15:0] a, d, keepRd;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy === 1'b0, busy, 0);
    chk("R1 done in reset", done === 1'b0, done, 0);
    chk("R1 error in reset", error === 1'b0, error, 0);
    chk("R1 ctl in reset", phyCtl === 20'd0, phyCtl, 0);
    rstN = 1'b1;
    quiet(2);
    chk("R1 ctl after reset", phyCtl === 20'd0 && busy === 1'b0, phyCtl, 0);

    // sweep of ack delays and data patterns
    for (int dl = 1; dl <= 3; dl++) begin
      for (int p = 0; p < 2; p++) begin
        ackDly = dl; mode = 0;
        a = p ? 16'h1234 : 16'h00F1;
        d = p ? 16'hBEEF : 16'h0A0C;
        quiet(4);
        launch(1'b0, a, d);
        waitDone(n);
        chk("R5 write done cycle", n == 3 * (2 * dl + 3), n, 3 * (2 * dl + 3));
        chk("R11 write no error", error === 1'b0, error, 0);
        afterDone();
        expWrite(a, d);
        checkLog("R2 write sequence");

        quiet(4);
        launch(1'b1, a ^ 16'h0F0F, 16'h7777);
        waitDone(n);
        chk("R5 read done cycle", n == 2 * (2 * dl + 3), n, 2 * (2 * dl + 3));
        chk("R6 read data", rdata === ((a ^ 16'h0F0F) ^ 16'hA5C3), rdata, (a ^ 16'h0F0F) ^ 16'hA5C3);
        afterDone();
        expRead(a ^ 16'h0F0F);
        checkLog("R3 read sequence");
      end
    end
    keepRd = rdata;

    // last allowed ack sample still succeeds
    ackDly = NWAIT - 1; mode = 0;
    quiet(4);
    launch(1'b0, 16'h0345, 16'h0678);
    waitDone(n);
    chk("R7 boundary success cycle", n == 3 * (2 * (NWAIT - 1) + 3), n, 3 * (2 * (NWAIT - 1) + 3));
    chk("R7 boundary no error", error === 1'b0, error, 0);
    chk("R6 rdata held over write", rdata === keepRd, rdata, keepRd);
    afterDone();

    // one cycle later: rise timeout
    ackDly = NWAIT;
    quiet(4);
    launch(1'b0, 16'h0345, 16'h0678);
    waitDone(n);
    chk("R7 rise timeout cycle", n == 1 + NWAIT, n, 1 + NWAIT);
    chk("R7 error set", error === 1'b1, error, 1);
    chk("R7 phase rise", errPhase === 1'b0, errPhase, 0);
    chk("R7 ctl cleared", phyCtl === 20'd0, phyCtl, 0);
    afterDone();
    expN = 0; push(20'h00D14); push(20'h00D15); push(20'd0);
    checkLog("R7 no further steps");
    quiet(40);

    // PHY that never acks, on a read
    ackDly = 1; mode = 1;
    launch(1'b1, 16'h0055, 16'h0);
    waitDone(n);
    chk("R7 read rise timeout cycle", n == 1 + NWAIT, n, 1 + NWAIT);
    chk("R7 read phase rise", error === 1'b1 && errPhase === 1'b0, {error, errPhase}, 2);
    chk("R6 rdata held over timeout", rdata === keepRd, rdata, keepRd);
    afterDone();
    chk("R11 error held while idle", error === 1'b1, error, 1);

    // ack that never falls
    ackDly = 1; mode = 2;
    quiet(4);
    chk("R11 error kept until start", error === 1'b1, error, 1);
    launch(1'b0, 16'h0101, 16'h0202);
    waitDone(n);
    chk("R8 fall timeout cycle", n == 1 + 2 + NWAIT, n, 1 + 2 + NWAIT);
    chk("R8 phase fall", error === 1'b1 && errPhase === 1'b1, {error, errPhase}, 3);
    afterDone();
    expN = 0; push(20'h00404); push(20'h00405); push(20'h00404); push(20'd0);
    checkLog("R8 no further steps");

    // clean write clears error
    mode = 0; ackDly = 2;
    quiet(6);
    launch(1'b0, 16'h0033, 16'h0044);
    chk("R11 error cleared on start", error === 1'b0 && errPhase === 1'b0, {error, errPhase}, 0);
    waitDone(n);
    chk("R11 clean after timeout", error === 1'b0, error, 0);
    afterDone();

    // start while busy is ignored
    quiet(4);
    launch(1'b0, 16'h0C0D, 16'h0E0F);
    repeat (3) @(negedge clk);
    start = 1'b1; opRead = 1'b1; addr = 16'h0999;
    repeat (2) @(negedge clk);
    start = 1'b0;
    waitDone(n);
    afterDone();
    expWrite(16'h0C0D, 16'h0E0F);
    checkLog("R9 second start ignored");
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (busy || done) n++;
    end
    chk("R9 no extra transaction", n == 0, n, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule